// File: doc/BRIEF.md
# Sweep Conversion Sequencer with FIFO Interrupt

This block drives a multi-channel converter through its conversion runs. A one-cycle `go` pulse starts a run. On each cycle where `startReq` is high, the block shows a channel number on `chanNext`. Each `convDone` pulse returns a 10-bit raw result, which the block formats and presents together with a one-cycle `fifoWr` strobe. The 2-bit mode field picks one of four run types: a single conversion, endless conversions of one channel, one pass through a sweep pattern, or sweep passes that repeat without end. The 2-bit pattern field picks the channel order used in the sweep modes.

The block counts filled result-store levels but holds no result data itself. A shared status pin carries one of two signals. The first is an active-low interrupt, which fires when the fill level reaches a programmable threshold and clears when the host starts to read. The second is an end-of-conversion flag, which is low while a conversion is in flight. The trigger field sets both the sweep length and the interrupt threshold, and it has effect only in the sweep modes.

Top module: `sweep_sequencer`

## Requirements
- R1: Out of reset, `startReq` and `fifoWr` are low and `pinOut` is high.
- R2: In mode 00, `go` issues exactly one `startReq` with `chanNext` equal to `selChan`. The block then goes idle.
- R3: In mode 01, every conversion requests `selChan` again, and requests continue until `abort`.
- R4: With 8 channels, a sweep follows these patterns: pattern 00 is 0,1,2,3,4,5,6,7; 01 is 0,2,4,6,0,2,4,6; 10 is 0,0,2,2,4,4,6,6; 11 is 0,2,0,2,0,2,0,2.
- R5: With 4 channels, pattern 01 is 0,1,2,3,0,1,2,3; 10 is 0,0,1,1,2,2,3,3; 11 is 0,1,0,1,0,1,0,1. Pattern 00 behaves as 01.
- R6: In mode 10, a pass has 8, 6, 4 or 2 conversions for trigger values 00, 01, 10, 11. After the pass the block goes idle.
- R7: In mode 11, after the last entry of the pass the sweep wraps to the first pattern entry and continues.
- R8: When `fmtTwos`=0, `result` equals the raw value. When `fmtTwos`=1, `result` equals the raw value with bit 9 inverted.
- R9: `fifoWr` is high for the one cycle after an accepted `convDone`, and `result` is valid in that cycle. A `convDone` while idle is ignored.
- R10: When `pinSelEoc`=0, `pinOut` is an active-low interrupt. It goes low when the filled level reaches the sweep length (sweep modes) or 1 (other modes). It stays low until `fifoRead`, and `fifoRead` also empties the level count.
- R11: When `pinSelEoc`=1, `pinOut` goes low in the cycle after `startReq` and returns high with the completing `convDone`.
- R12: If `fifoRead` and `convDone` fall in the same cycle, the read empties the level first and the new result counts as level 1.
- R13: `abort` stops any run at once, and no further `startReq` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Starts a run when idle |
| abort | input | 1 | Stops the current run |
| convMode | input | 2 | Run type: single, repeat, sweep, repeated sweep |
| patternSel | input | 2 | Sweep channel pattern |
| trigSel | input | 2 | Sweep length and interrupt threshold |
| pinSelEoc | input | 1 | 0: interrupt on pin, 1: end-of-conversion on pin |
| fmtTwos | input | 1 | 0: straight binary, 1: two's complement |
| selChan | input | CH_W | Channel for modes 00 and 01 |
| convDone | input | 1 | Conversion complete strobe |
| rawResult | input | RES_W | Raw converter result |
| fifoRead | input | 1 | Host begins reading the result store |
| chanNext | output | CH_W | Channel to convert, valid with startReq |
| startReq | output | 1 | One-cycle conversion start request |
| result | output | RES_W | Formatted result |
| fifoWr | output | 1 | Result store write strobe |
| pinOut | output | 1 | Shared interrupt / end-of-conversion pin |

## Verification
The host read that clears the level and a newly finished conversion that adds to it can land in the same cycle. The bench forces this in a repeated sweep with a threshold of four. It first fills three levels, then raises `fifoRead` and `convDone` together. The run passes only if the interrupt stays released for the next two conversions and falls on the third, which shows that the new result counted as level 1 rather than being lost or masking the read.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_SWEEP  = 2'b10,
    MODE_LOOP   = 2'b11
  } convMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic capture;
  } seqStrobes_t;

endpackage

// File: rtl/sweep_seq_ctrl.sv
module sweep_seq_ctrl
  import sweep_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int IDX_W      = 3,
  parameter int LVL_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic             abort,
  input  logic [1:0]       convMode,
  input  logic [1:0]       trigSel,
  input  logic             convDone,
  input  logic             fifoRead,
  input  logic [IDX_W-1:0] curIdx,
  output seqStrobes_t      strb,
  output logic             startReq,
  output logic             eocOut,
  output logic             intN
);

  localparam int QUARTER = FIFO_DEPTH / 4;

  convMode_e        mode;
  logic             busy, busyNxt, startNxt;
  logic [LVL_W-1:0] level, levelBase, levelNxt;
  logic [LVL_W-1:0] seqLen;
  logic             lastEntry;

  assign mode = convMode_e'(convMode);

  // sweep length doubles as the interrupt threshold
  always_comb begin
    if (convMode[1]) seqLen = LVL_W'(QUARTER * (4 - int'(trigSel)));
    else             seqLen = LVL_W'(1);
  end

  assign lastEntry = (LVL_W'(curIdx) == seqLen - LVL_W'(1));

  always_comb begin
    strb     = '0;
    startNxt = 1'b0;
    busyNxt  = busy;
    if (abort) begin
      busyNxt = 1'b0;
    end else if (!busy) begin
      if (go) begin
        busyNxt     = 1'b1;
        startNxt    = 1'b1;
        strb.clrIdx = 1'b1;
      end
    end else if (convDone) begin
      strb.capture = 1'b1;
      unique case (mode)
        MODE_SINGLE: busyNxt = 1'b0;
        MODE_REPEAT: startNxt = 1'b1;
        MODE_SWEEP: begin
          if (lastEntry) busyNxt = 1'b0;
          else begin
            startNxt    = 1'b1;
            strb.incIdx = 1'b1;
          end
        end
        default: begin
          startNxt = 1'b1;
          if (lastEntry) strb.clrIdx = 1'b1;
          else           strb.incIdx = 1'b1;
        end
      endcase
    end
  end

  // read empties the count before a simultaneous write is added
  always_comb begin
    levelBase = fifoRead ? '0 : level;
    levelNxt  = levelBase;
    if (strb.capture && (levelBase != LVL_W'(FIFO_DEPTH)))
      levelNxt = levelBase + LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      startReq <= 1'b0;
      eocOut   <= 1'b1;
      intN     <= 1'b1;
      level    <= '0;
    end else begin
      busy     <= busyNxt;
      startReq <= startNxt;
      level    <= levelNxt;
      if (abort || strb.capture) eocOut <= 1'b1;
      else if (startReq)         eocOut <= 1'b0;
      if (strb.capture && (levelNxt >= seqLen)) intN <= 1'b0;
      else if (fifoRead)                        intN <= 1'b1;
    end
  end

endmodule

// File: rtl/sweep_seq_dp.sv
module sweep_seq_dp
  import sweep_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int IDX_W  = 3,
  parameter int CH_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strb,
  input  logic             sweepMode,
  input  logic [1:0]       patternSel,
  input  logic [CH_W-1:0]  selChan,
  input  logic             fmtTwos,
  input  logic [RES_W-1:0] rawResult,
  output logic [IDX_W-1:0] curIdx,
  output logic [CH_W-1:0]  chanNext,
  output logic [RES_W-1:0] result,
  output logic             fifoWr
);

  logic [CH_W-1:0] patChan;

  generate
    if (NUM_CH == 4) begin : g_four
      always_comb begin
        unique case (patternSel)
          2'b10:   patChan = curIdx[2:1];
          2'b11:   patChan = {1'b0, curIdx[0]};
          default: patChan = curIdx[1:0];   // 00 falls back to 01
        endcase
      end
    end else begin : g_eight
      always_comb begin
        unique case (patternSel)
          2'b00:   patChan = curIdx;
          2'b01:   patChan = {curIdx[1:0], 1'b0};
          2'b10:   patChan = {curIdx[2:1], 1'b0};
          default: patChan = {1'b0, curIdx[0], 1'b0};
        endcase
      end
    end
  endgenerate

  assign chanNext = sweepMode ? patChan : selChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx <= '0;
      result <= '0;
      fifoWr <= 1'b0;
    end else begin
      if (strb.clrIdx)      curIdx <= '0;
      else if (strb.incIdx) curIdx <= curIdx + IDX_W'(1);
      fifoWr <= strb.capture;
      if (strb.capture)
        result <= {rawResult[RES_W-1] ^ fmtTwos, rawResult[RES_W-2:0]};
    end
  end

endmodule

// File: rtl/sweep_sequencer.sv
module sweep_sequencer
  import sweep_seq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int RES_W      = 10,
  parameter int FIFO_DEPTH = 8,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic             abort,
  input  logic [1:0]       convMode,
  input  logic [1:0]       patternSel,
  input  logic [1:0]       trigSel,
  input  logic             pinSelEoc,
  input  logic             fmtTwos,
  input  logic [CH_W-1:0]  selChan,
  input  logic             convDone,
  input  logic [RES_W-1:0] rawResult,
  input  logic             fifoRead,
  output logic [CH_W-1:0]  chanNext,
  output logic             startReq,
  output logic [RES_W-1:0] result,
  output logic             fifoWr,
  output logic             pinOut
);

  localparam int IDX_W = $clog2(FIFO_DEPTH);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  seqStrobes_t      strb;
  logic [IDX_W-1:0] curIdx;
  logic             eocOut, intN;

  sweep_seq_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .abort(abort), .convMode(convMode),
    .trigSel(trigSel), .convDone(convDone), .fifoRead(fifoRead),
    .curIdx(curIdx), .strb(strb), .startReq(startReq), .eocOut(eocOut),
    .intN(intN)
  );

  sweep_seq_dp #(.NUM_CH(NUM_CH), .RES_W(RES_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sweepMode(convMode[1]),
    .patternSel(patternSel), .selChan(selChan), .fmtTwos(fmtTwos),
    .rawResult(rawResult), .curIdx(curIdx), .chanNext(chanNext),
    .result(result), .fifoWr(fifoWr)
  );

  assign pinOut = pinSelEoc ? eocOut : intN;

endmodule

// File: rtl/sweep_sequencer_chk.sv
module sweep_sequencer_chk #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             abort,
  input logic [1:0]       convMode,
  input logic [1:0]       patternSel,
  input logic             pinSelEoc,
  input logic             fmtTwos,
  input logic [CH_W-1:0]  selChan,
  input logic             convDone,
  input logic [RES_W-1:0] rawResult,
  input logic             fifoRead,
  input logic [CH_W-1:0]  chanNext,
  input logic             startReq,
  input logic [RES_W-1:0] result,
  input logic             fifoWr,
  input logic             pinOut
);

  a_r9_wr_follows_done: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> $past(convDone));

  a_r8_twos_flips_msb: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWr && $past(fmtTwos)) |->
      (result == {~$past(rawResult[RES_W-1]), $past(rawResult[RES_W-2:0])}));

  a_r11_eoc_low_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !convDone && !abort && pinSelEoc) |=> (!pinSelEoc || !pinOut));

  a_r10_read_releases_int: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRead && !convDone) |=> (pinSelEoc || pinOut));

  a_r2_fixed_channel: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !convMode[1]) |-> (chanNext == selChan));

  a_r13_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> !startReq);

  generate
    if (NUM_CH == 8) begin : g_even
      a_r4_even_patterns: assert property (@(posedge clk) disable iff (!rstN)
        (startReq && convMode[1] && (patternSel != 2'b00)) |-> !chanNext[0]);
    end
  endgenerate

endmodule

bind sweep_sequencer sweep_sequencer_chk #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .abort(abort), .convMode(convMode),
  .patternSel(patternSel), .pinSelEoc(pinSelEoc), .fmtTwos(fmtTwos),
  .selChan(selChan), .convDone(convDone), .rawResult(rawResult),
  .fifoRead(fifoRead), .chanNext(chanNext), .startReq(startReq),
  .result(result), .fifoWr(fifoWr), .pinOut(pinOut)
);

// File: tb/sweep_sequencer_bench.sv
module sweep_sequencer_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, go, abort, convDone, fifoRead, pinSelEoc, fmtTwos;
  logic [1:0] convMode, patternSel, trigSel;
  logic [2:0] selChan;
  logic [9:0] rawResult;

  logic [2:0] chanNext;
  logic       startReq, fifoWr, pinOut;
  logic [9:0] result;
  logic [1:0] chan4;
  logic       start4, wr4, pin4;
  logic [9:0] res4;

  int nChecks = 0;
  int nFails  = 0;

  sweep_sequencer u_sweep_sequencer (
    .clk(clk), .rstN(rstN), .go(go), .abort(abort), .convMode(convMode),
    .patternSel(patternSel), .trigSel(trigSel), .pinSelEoc(pinSelEoc),
    .fmtTwos(fmtTwos), .selChan(selChan), .convDone(convDone),
    .rawResult(rawResult), .fifoRead(fifoRead), .chanNext(chanNext),
    .startReq(startReq), .result(result), .fifoWr(fifoWr), .pinOut(pinOut)
  );

  sweep_sequencer #(.NUM_CH(4)) u_sweep_sequencer4 (
    .clk(clk), .rstN(rstN), .go(go), .abort(abort), .convMode(convMode),
    .patternSel(patternSel), .trigSel(trigSel), .pinSelEoc(pinSelEoc),
    .fmtTwos(fmtTwos), .selChan(selChan[1:0]), .convDone(convDone),
    .rawResult(rawResult), .fifoRead(fifoRead), .chanNext(chan4),
    .startReq(start4), .result(res4), .fifoWr(wr4), .pinOut(pin4)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp8(input int pat, input int i);
    case (pat)
      0:       return i;
      1:       return (2 * i) % 8;
      2:       return (i / 2) * 2;
      default: return (i % 2) * 2;
    endcase
  endfunction

  function automatic int exp4(input int pat, input int i);
    case (pat)
      2:       return i / 2;
      3:       return i % 2;
      default: return i % 4;
    endcase
  endfunction

  task automatic pulseGo();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic cleanup();
    @(negedge clk); abort = 1'b1; fifoRead = 1'b1;
    @(negedge clk); abort = 1'b0; fifoRead = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitStart(input int limit, output bit seen, output int ch, output int ch4);
    seen = 1'b0; ch = -1; ch4 = -1;
    for (int i = 0; i < limit; i++) begin
      if (startReq) begin
        seen = 1'b1; ch = int'(chanNext); ch4 = int'(chan4);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulseDone(input logic [9:0] raw, output bit eocDuring);
    @(negedge clk);
    eocDuring = pinOut;
    convDone = 1'b1; rawResult = raw;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic testReset();
    check(!startReq, "R1", "startReq after reset", int'(startReq), 0);
    check(!fifoWr, "R1", "fifoWr after reset", int'(fifoWr), 0);
    check(pinOut, "R1", "pinOut after reset", int'(pinOut), 1);
  endtask

  task automatic testSingle();
    bit seen, e; int ch, ch4;
    convMode = 2'b00; selChan = 3'd5; pinSelEoc = 1'b0; fmtTwos = 1'b0;
    pulseGo();
    waitStart(10, seen, ch, ch4);
    check(seen && ch == 5, "R2", "single channel", ch, 5);
    check(ch4 == 1, "R2", "single channel 4ch", ch4, 1);
    pulseDone(10'h155, e);
    check(fifoWr, "R9", "write strobe", int'(fifoWr), 1);
    check(result == 10'h155, "R8", "unipolar result", int'(result), 'h155);
    check(!pinOut, "R10", "interrupt after single", int'(pinOut), 0);
    @(negedge clk);
    check(!fifoWr, "R9", "write strobe one cycle", int'(fifoWr), 0);
    waitStart(8, seen, ch, ch4);
    check(!seen, "R2", "idle after single", int'(seen), 0);
    check(!pinOut, "R10", "interrupt held", int'(pinOut), 0);
    @(negedge clk); fifoRead = 1'b1;
    @(negedge clk); fifoRead = 1'b0;
    check(pinOut, "R10", "interrupt released by read", int'(pinOut), 1);
    cleanup();
  endtask

  task automatic testRepeat();
    bit seen, e; int ch, ch4;
    convMode = 2'b01; selChan = 3'd3;
    pulseGo();
    for (int k = 0; k < 3; k++) begin
      waitStart(10, seen, ch, ch4);
      check(seen && ch == 3, "R3", "repeat channel", ch, 3);
      pulseDone(10'(k), e);
    end
    waitStart(4, seen, ch, ch4);
    check(seen, "R3", "repeat continues", int'(seen), 1);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    waitStart(8, seen, ch, ch4);
    check(!seen, "R13", "no request after abort", int'(seen), 0);
    cleanup();
  endtask

  task automatic runSweep(input int pat, input int trig, input int len);
    bit seen, e; int ch, ch4;
    convMode = 2'b10; patternSel = 2'(pat); trigSel = 2'(trig); pinSelEoc = 1'b0;
    pulseGo();
    for (int k = 0; k < len; k++) begin
      waitStart(10, seen, ch, ch4);
      check(seen, "R6", "sweep entry requested", int'(seen), 1);
      check(ch == exp8(pat, k), "R4", "8ch pattern channel", ch, exp8(pat, k));
      check(ch4 == exp4(pat, k), "R5", "4ch pattern channel", ch4, exp4(pat, k));
      pulseDone(10'(k * 7), e);
      check(fifoWr, "R9", "sweep write", int'(fifoWr), 1);
      check(pinOut == (k != len - 1), "R10", "interrupt at threshold",
            int'(pinOut), int'(k != len - 1));
    end
    waitStart(8, seen, ch, ch4);
    check(!seen, "R6", "idle after pass", int'(seen), 0);
    cleanup();
  endtask

  task automatic testLoop();
    bit seen, e; int ch, ch4;
    convMode = 2'b11; patternSel = 2'b01; trigSel = 2'b11;
    pulseGo();
    for (int k = 0; k < 5; k++) begin
      waitStart(10, seen, ch, ch4);
      check(seen && ch == (k % 2) * 2, "R7", "wrap channel", ch, (k % 2) * 2);
      pulseDone(10'h0, e);
    end
    cleanup();
  endtask

  task automatic testFormat(input logic [9:0] raw, input bit twos, input logic [9:0] exp);
    bit seen, e; int ch, ch4;
    convMode = 2'b00; fmtTwos = twos;
    pulseGo();
    waitStart(10, seen, ch, ch4);
    pulseDone(raw, e);
    check(result == exp, "R8", "formatted result", int'(result), int'(exp));
    fmtTwos = 1'b0;
    cleanup();
  endtask

  task automatic testIgnoreIdle();
    bit seen; int ch, ch4;
    pinSelEoc = 1'b0;
    @(negedge clk); convDone = 1'b1; rawResult = 10'h3AA;
    @(negedge clk); convDone = 1'b0;
    check(!fifoWr, "R9", "idle done ignored", int'(fifoWr), 0);
    check(pinOut, "R9", "idle done no interrupt", int'(pinOut), 1);
    waitStart(4, seen, ch, ch4);
    check(!seen, "R9", "idle done no request", int'(seen), 0);
  endtask

  task automatic testEoc();
    bit seen, e; int ch, ch4;
    convMode = 2'b00; pinSelEoc = 1'b1;
    check(pinOut, "R11", "eoc idle high", int'(pinOut), 1);
    pulseGo();
    waitStart(10, seen, ch, ch4);
    pulseDone(10'h1, e);
    check(!e, "R11", "eoc low during conversion", int'(e), 0);
    check(pinOut, "R11", "eoc high after done", int'(pinOut), 1);
    pinSelEoc = 1'b0;
    cleanup();
  endtask

  task automatic testCollision();
    bit seen, e; int ch, ch4;
    convMode = 2'b11; patternSel = 2'b00; trigSel = 2'b10; pinSelEoc = 1'b0;
    pulseGo();
    for (int k = 0; k < 3; k++) begin
      waitStart(10, seen, ch, ch4);
      pulseDone(10'h0, e);
    end
    check(pinOut, "R12", "below threshold before collision", int'(pinOut), 1);
    waitStart(10, seen, ch, ch4);
    @(negedge clk); convDone = 1'b1; fifoRead = 1'b1;
    @(negedge clk); convDone = 1'b0; fifoRead = 1'b0;
    check(fifoWr, "R12", "write in collision", int'(fifoWr), 1);
    check(pinOut, "R12", "level restarts at one", int'(pinOut), 1);
    for (int k = 0; k < 3; k++) begin
      waitStart(10, seen, ch, ch4);
      pulseDone(10'h0, e);
      check(pinOut == (k != 2), "R12", "threshold after collision",
            int'(pinOut), int'(k != 2));
    end
    cleanup();
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; go = 1'b0; abort = 1'b0; convDone = 1'b0; fifoRead = 1'b0;
    pinSelEoc = 1'b0; fmtTwos = 1'b0; convMode = 2'b00; patternSel = 2'b00;
    trigSel = 2'b00; selChan = 3'd0; rawResult = 10'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testRepeat();
    for (int p = 0; p < 4; p++) runSweep(p, 0, 8);
    runSweep(0, 1, 6);
    runSweep(0, 2, 4);
    runSweep(0, 3, 2);
    testLoop();
    testFormat(10'h000, 1'b1, 10'h200);
    testFormat(10'h3FF, 1'b1, 10'h1FF);
    testFormat(10'h2A5, 1'b0, 10'h2A5);
    testIgnoreIdle();
    testEoc();
    testCollision();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule